// File: doc/BRIEF.md
# Dual-Constraint Rate-Half Convolutional Encoder

This block turns a serial bit stream into two code symbols per input bit. It uses a rate 1/2 convolutional code whose constraint length is 7 or 9, picked at run time by a select input. Both code families share one 9-bit history register, so the length select only changes which taps are summed. A strobe input marks the system-clock cycles that count as data-clock edges. The block does nothing on any other cycle.

The differential stage is optional and comes first. When it is on, the bit written into the history is the input bit XORed with the previously written bit. The optional G2 inversion comes after the tap sums. The output register adds one strobe of latency, so the symbols for a bit are visible after the strobe that follows the one that loaded it. The scrambler mode field takes four values. Value 01 inverts G2. Value 00 and the two values reserved for a self-synchronising scrambler (10, 11) pass the symbols through unchanged.

The mode and length encodings are kept in a package as enumerated types. The output stage decodes the mode with a unique case over all four values.

Top module: `cenc_dual_k`

## Requirements
- R1: The history register takes exactly one bit on each clock edge where `data_en` is 1, shifting older bits up and putting the new bit at position 0. On edges where `data_en` is 0, neither the history nor the outputs change.
- R2: With `k_long` = 0, G1 is the XOR of history positions {0,1,2,3,6} and G2 is the XOR of positions {0,2,3,5,6} (generators 171 and 133 octal, with the newest bit taking the generator MSB). Positions 7 and 8 have no effect.
- R3: With `k_long` = 1, G1 is the XOR of history positions {0,1,2,3,5,7,8} and G2 is the XOR of positions {0,2,3,4,8} (generators 753 and 561 octal).
- R4: The symbols for a bit sampled on strobe n appear on `sym_g1`/`sym_g2` after strobe n+1 and hold until strobe n+2. Before that, the outputs reflect the earlier history.
- R5: With `diff_on` = 1, the bit written into history position 0 is `bit_in` XOR the bit previously at position 0.
- R6: With `diff_on` = 0, `bit_in` is written into the history unchanged.
- R7: With `scr_mode` = 2'b01, `sym_g2` is the inverse of the tap sum and `sym_g1` is unaffected.
- R8: With `scr_mode` = 2'b00, 2'b10 or 2'b11, both symbols are the plain tap sums.
- R9: While `rst_n` is 0, the history and both outputs are 0, and this takes effect without waiting for a clock edge.
- R10: Changing `k_long` between strobes needs no flush. The next output uses the new tap set over the history bits already stored, including bits 7 and 8 written while length 7 was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_en | input | 1 | Data-clock strobe; one bit is consumed per high cycle |
| bit_in | input | 1 | Serial input bit |
| k_long | input | 1 | 0 selects constraint length 7, 1 selects length 9 |
| diff_on | input | 1 | Enables differential coding ahead of the shift register |
| scr_mode | input | 2 | 00 off, 01 invert G2, 10/11 pass-through |
| sym_g1 | output | 1 | First code symbol (registered) |
| sym_g2 | output | 1 | Second code symbol (registered) |

## Verification
The hardest case to reach from the ports is a history whose bits 7 and 8 differ from the newer bits. That is the only way to tell whether the length-7 taps truly ignore the upper bits, and whether a run-time switch to length 9 picks them up. The bench reaches this case by pushing two ones followed by zeros. It then reads the output once with length 7 selected. It replays the same pattern and flips to length 9 on the final strobe, so the upper bits alone decide G2. The first-output latency is pinned down from a cleared register, where a single one must show up exactly one strobe late.

// File: rtl/cenc_pkg.sv
package cenc_pkg;

    typedef enum logic {
        CODE_K7 = 1'b0,
        CODE_K9 = 1'b1
    } code_len_e;

    typedef enum logic [1:0] {
        SCR_OFF    = 2'b00,
        SCR_INV_G2 = 2'b01,
        SCR_SS_A   = 2'b10,
        SCR_SS_B   = 2'b11
    } scr_mode_e;

endpackage

// File: rtl/cenc_history.sv
module cenc_history #(
    parameter int HIST_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              bit_in,
    input  logic              diff_on,
    output logic [HIST_W-1:0] hist
);
    // The newest history bit doubles as the differential memory
    logic coded;
    assign coded = bit_in ^ (diff_on & hist[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (step) begin
            hist <= {hist[HIST_W-2:0], coded};
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])); // R1
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(hist)); // R1
    AST_DIFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && diff_on) |=> hist[0] == ($past(bit_in) ^ $past(hist[0]))); // R5
    AST_RAW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !diff_on) |=> hist[0] == $past(bit_in)); // R6
    AST_HIST_RESET: assert property (@(posedge clk)
        !rst_n |-> hist == '0); // R9

endmodule

// File: rtl/cenc_symgen.sv
module cenc_symgen
    import cenc_pkg::*;
#(
    parameter int              HIST_W  = 9,
    parameter int              K_SHORT = 7,
    parameter int              K_LONG  = 9,
    parameter logic [HIST_W-1:0] GA_SHORT = 9'o171,
    parameter logic [HIST_W-1:0] GB_SHORT = 9'o133,
    parameter logic [HIST_W-1:0] GA_LONG  = 9'o753,
    parameter logic [HIST_W-1:0] GB_LONG  = 9'o561
) (
    input  logic [HIST_W-1:0] hist,
    input  logic              k_long,
    output logic              raw_g1,
    output logic              raw_g2
);
    // Generator MSB multiplies the newest bit (history position 0)
    function automatic logic [HIST_W-1:0] tap_mask(input logic [HIST_W-1:0] gen,
                                                   input int k);
        logic [HIST_W-1:0] m;
        m = '0;
        for (int i = 0; i < HIST_W; i++) begin
            if (i < k) m[i] = gen[k-1-i];
        end
        return m;
    endfunction

    localparam int NFAM = 2;
    localparam logic [HIST_W-1:0] MASK_A [NFAM] = '{tap_mask(GA_SHORT, K_SHORT),
                                                    tap_mask(GA_LONG,  K_LONG)};
    localparam logic [HIST_W-1:0] MASK_B [NFAM] = '{tap_mask(GB_SHORT, K_SHORT),
                                                    tap_mask(GB_LONG,  K_LONG)};

    logic [NFAM-1:0] sum_a;
    logic [NFAM-1:0] sum_b;

    for (genvar f = 0; f < NFAM; f++) begin : g_family
        assign sum_a[f] = ^(hist & MASK_A[f]);
        assign sum_b[f] = ^(hist & MASK_B[f]);
    end

    always_comb begin
        unique case (code_len_e'(k_long))
            CODE_K7: begin
                raw_g1 = sum_a[0];
                raw_g2 = sum_b[0];
            end
            CODE_K9: begin
                raw_g1 = sum_a[1];
                raw_g2 = sum_b[1];
            end
            default: begin
                raw_g1 = 1'b0;
                raw_g2 = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cenc_outstage.sv
module cenc_outstage
    import cenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [1:0] scr_mode,
    input  logic       raw_g1,
    input  logic       raw_g2,
    output logic       sym_g1,
    output logic       sym_g2
);
    logic flip_g2;

    always_comb begin
        unique case (scr_mode_e'(scr_mode))
            SCR_OFF:    flip_g2 = 1'b0;
            SCR_INV_G2: flip_g2 = 1'b1;
            SCR_SS_A:   flip_g2 = 1'b0;
            SCR_SS_B:   flip_g2 = 1'b0;
            default:    flip_g2 = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_g1 <= 1'b0;
            sym_g2 <= 1'b0;
        end else if (step) begin
            sym_g1 <= raw_g1;
            sym_g2 <= raw_g2 ^ flip_g2;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sym_g1) && $stable(sym_g2)); // R4
    AST_G2_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && scr_mode == 2'b01) |=> sym_g2 != $past(raw_g2)); // R7
    AST_G2_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && scr_mode != 2'b01) |=> sym_g2 == $past(raw_g2)); // R8
    AST_G1_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> sym_g1 == $past(raw_g1)); // R7
    AST_OUT_RESET: assert property (@(posedge clk)
        !rst_n |-> !sym_g1 && !sym_g2); // R9

endmodule

// File: rtl/cenc_dual_k.sv
module cenc_dual_k #(
    parameter int HIST_W  = 9,
    parameter int K_SHORT = 7,
    parameter int K_LONG  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_en,
    input  logic       bit_in,
    input  logic       k_long,
    input  logic       diff_on,
    input  logic [1:0] scr_mode,
    output logic       sym_g1,
    output logic       sym_g2
);
    logic [HIST_W-1:0] hist;
    logic              raw_g1;
    logic              raw_g2;

    cenc_history #(.HIST_W(HIST_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (data_en),
        .bit_in  (bit_in),
        .diff_on (diff_on),
        .hist    (hist)
    );

    cenc_symgen #(
        .HIST_W  (HIST_W),
        .K_SHORT (K_SHORT),
        .K_LONG  (K_LONG)
    ) u_sym (
        .hist   (hist),
        .k_long (k_long),
        .raw_g1 (raw_g1),
        .raw_g2 (raw_g2)
    );

    cenc_outstage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (data_en),
        .scr_mode (scr_mode),
        .raw_g1   (raw_g1),
        .raw_g2   (raw_g2),
        .sym_g1   (sym_g1),
        .sym_g2   (sym_g2)
    );

endmodule

// File: tb/sim_cenc_dual_k.sv
module sim_cenc_dual_k;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       k_long = 1'b0;
    logic       diff_on = 1'b0;
    logic [1:0] scr_mode = 2'b00;
    logic       sym_g1;
    logic       sym_g2;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Hand-derived tap masks, bit i = history position i
    localparam logic [8:0] M_A7 = 9'h04F;
    localparam logic [8:0] M_B7 = 9'h06D;
    localparam logic [8:0] M_A9 = 9'h1AF;
    localparam logic [8:0] M_B9 = 9'h11D;

    logic [8:0] m_hist = '0;
    logic       m_g1 = 1'b0;
    logic       m_g2 = 1'b0;

    always #5 clk = ~clk;

    cenc_dual_k u0 (
        .clk(clk), .rst_n(rst_n), .data_en(data_en), .bit_in(bit_in),
        .k_long(k_long), .diff_on(diff_on), .scr_mode(scr_mode),
        .sym_g1(sym_g1), .sym_g2(sym_g2)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " g1"}, sym_g1, m_g1);
        chk({tag, " g2"}, sym_g2, m_g2);
    endtask

    // One strobe; the model follows the requirements
    task automatic step(input logic b);
        logic d;
        @(negedge clk);
        bit_in  = b;
        data_en = 1'b1;
        @(negedge clk);
        data_en = 1'b0;
        m_g1 = ^(m_hist & (k_long ? M_A9 : M_A7));
        m_g2 = ^(m_hist & (k_long ? M_B9 : M_B7)) ^ (scr_mode == 2'b01);
        d = b ^ (diff_on & m_hist[0]);
        m_hist = {m_hist[7:0], d};
    endtask

    task automatic do_reset();
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        m_hist = '0; m_g1 = 1'b0; m_g2 = 1'b0;
        chk("R9 async clear g1", sym_g1, 1'b0);
        chk("R9 async clear g2", sym_g2, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        chk("R9 reset g1", sym_g1, 1'b0);
        chk("R9 reset g2", sym_g2, 1'b0);
    endtask

    task automatic t_latency();
        do_reset();
        k_long = 1'b0; diff_on = 1'b0; scr_mode = 2'b00;
        step(1'b1);
        chk("R4 first strobe still old g1", sym_g1, 1'b0);
        chk("R4 first strobe still old g2", sym_g2, 1'b0);
        step(1'b0);
        chk("R4 second strobe g1", sym_g1, 1'b1);
        chk("R4 second strobe g2", sym_g2, 1'b1);
    endtask

    task automatic t_k7_stream();
        do_reset();
        k_long = 1'b0;
        for (int i = 0; i < 40; i++) begin
            step(logic'(($urandom % 2)));
            chk_model("R2 K7 stream");
        end
    endtask

    task automatic t_k9_stream();
        do_reset();
        k_long = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step(logic'(($urandom % 2)));
            chk_model("R3 K9 stream");
        end
    endtask

    task automatic t_upper_bits(input logic switch_long);
        do_reset();
        k_long = 1'b0; diff_on = 1'b0; scr_mode = 2'b00;
        step(1'b1);
        step(1'b1);
        for (int i = 0; i < 7; i++) step(1'b0);
        if (switch_long) k_long = 1'b1;
        step(1'b0);
        if (switch_long) begin
            chk("R10 switch to K9 g1", sym_g1, 1'b0);
            chk("R10 switch to K9 g2", sym_g2, 1'b1);
        end else begin
            chk("R2 old bits ignored g1", sym_g1, 1'b0);
            chk("R2 old bits ignored g2", sym_g2, 1'b0);
        end
        k_long = 1'b0;
    endtask

    task automatic t_hold();
        logic h1;
        logic h2;
        do_reset();
        step(1'b1); step(1'b0); step(1'b1);
        h1 = sym_g1; h2 = sym_g2;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
            k_long = ~k_long;
        end
        @(negedge clk);
        k_long = 1'b0;
        chk("R1 idle hold g1", sym_g1, h1);
        chk("R1 idle hold g2", sym_g2, h2);
        step(1'b0);
        chk_model("R1 history untouched by idle");
        step(1'b0);
        chk_model("R1 history untouched by idle next");
    endtask

    task automatic t_diff();
        do_reset();
        diff_on = 1'b1;
        for (int i = 0; i < 30; i++) begin
            step(logic'(($urandom % 2)));
            chk_model("R5 differential stream");
        end
        diff_on = 1'b0;
        for (int i = 0; i < 12; i++) begin
            step(logic'(($urandom % 2)));
            chk_model("R6 raw stream");
        end
    endtask

    task automatic t_modes();
        do_reset();
        for (int m = 0; m < 4; m++) begin
            scr_mode = 2'(m);
            for (int i = 0; i < 12; i++) begin
                step(logic'(($urandom % 2)));
                if (m == 1) chk_model("R7 invert G2 mode");
                else        chk_model("R8 pass-through mode");
            end
        end
        scr_mode = 2'b00;
    endtask

    task automatic t_mixed();
        do_reset();
        for (int i = 0; i < 200; i++) begin
            k_long   = logic'(($urandom % 2));
            diff_on  = logic'(($urandom % 2));
            scr_mode = 2'(($urandom % 4));
            step(logic'(($urandom % 2)));
            chk_model("R10 mixed run-time settings");
        end
        k_long = 1'b0; diff_on = 1'b0; scr_mode = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_latency();
        t_k7_stream();
        t_k9_stream();
        t_upper_bits(1'b0);
        t_upper_bits(1'b1);
        t_hold();
        t_diff();
        t_modes();
        t_mixed();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule